// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

A clocked controller that sits between a synchronous request port and a static memory that has no clock of its own. A client presents an address, write data, two byte-lane enables, a read/write flag and a width flag (16-bit word access or 8-bit byte access) with a valid/ready handshake. The controller then drives the memory's address, its two chip selects (one active low, one active high), write enable, output enable, the two lane selects and the width pin. It also drives the per-pin enables of the data bus drivers.

Every analog interval of the memory is a parameter in nanoseconds. The controller turns each one into a whole number of clock cycles from the clock period parameter. A read holds all strobes for the longest of the cycle, address-access and output-enable intervals and then samples the bus. A write holds the write strobe for the longest of the cycle, pulse, address-to-end and data-setup intervals. A change of width is wrapped in a long deselected guard period on both sides of the width pin edge.

In byte mode the memory uses data pin 15 as its lowest address bit. The controller drives that pin from the request and moves data only on pins 0 to 7.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: Each interval is ceil(ns / CLK_PERIOD_NS) cycles and never less than one. A read keeps output enable low for max(read cycle, address access, output enable access) cycles. A write keeps write enable low for max(write cycle, pulse, address-to-end, data setup) cycles.
- R2: A read asserts both chip selects, the enabled lane selects and output enable (low) together for the read length. It samples the bus at the last edge of that window. It returns the data in a single-cycle rsp_valid pulse in the next cycle. Lanes whose enable is clear read as zero.
- R3: A write asserts both chip selects, the enabled lane selects, write enable (low) and the data drivers together for the write length. Write enable rises while the address is held for one more cycle. Write enable and output enable are never low in the same cycle.
- R4: req_ready is high only when the controller is idle. A request is accepted on a clock edge with req_valid and req_ready both high, and req_ready stays low until its sequence has finished.
- R5: The data-lane drivers are enabled only while write enable is low. After output enable is released, at least one cycle passes before any data lane is driven.
- R6: In byte mode (mem_byte_n low) req_addr[0] is driven on data pin 15 whenever the controller is in byte mode. Data pins 8 to 14 are never driven, data moves on pins 0 to 7, and only req_be[0] qualifies the access. In word mode (mem_byte_n high) req_addr[0] is ignored, the memory address is req_addr[ADDR_W:1], and req_be[1] and req_be[0] select the upper and lower lanes.
- R7: mem_byte_n changes only after the chip has been deselected for at least ceil(T_MODE_NS / CLK_PERIOD_NS) cycles. The chip then stays deselected for at least that many cycles after the change.
- R8: A request with no lane enabled (req_be == 0 in word mode, req_be[0] == 0 in byte mode) asserts no chip select, changes no memory content and does not change the width. For a read it returns zero in the response pulse.
- R9: After reset the chip is deselected, write and output enables are high, no data driver is enabled, word mode is selected and req_ready is high.
- R10: Whenever req_ready is high the chip is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte_mode | input | 1 | 1 = 8-bit access, 0 = 16-bit access |
| req_addr | input | ADDR_W+1 | Byte address; bit 0 used only in byte mode |
| req_wdata | input | 16 | Write data; bits 7:0 only in byte mode |
| req_be | input | 2 | Lane enables; bit 0 lower, bit 1 upper |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data |
| mem_addr | output | ADDR_W | Memory word address |
| mem_cs1_n | output | 1 | Chip select, active low |
| mem_cs2 | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_byte_n | output | 1 | Width pin, low = byte mode |
| mem_dq_out | output | 16 | Data bus value to drive |
| mem_dq_oe | output | 16 | Per-pin driver enable |
| mem_dq_in | input | 16 | Data bus value sampled |

## Verification
Two functions can fall in the same cycle: the read response pulse and the bus turnaround cycle that follows output enable release. If a write is already waiting, the controller must not start driving the bus in that same cycle. The bench provokes this by issuing a write directly behind a read with req_valid held. It judges the result by checking, cycle by cycle, that no data lane is enabled while output enable is low or in the cycle after it rises. The scoreboard confirms that the read data returned and the value later read back from the written address are both correct.

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 20,
  parameter int T_RC_NS       = 45,
  parameter int T_AA_NS       = 45,
  parameter int T_OE_NS       = 30,
  parameter int T_WC_NS       = 45,
  parameter int T_WP_NS       = 35,
  parameter int T_AW_NS       = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_MODE_NS     = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_byte_mode,
  input  logic [ADDR_W:0]   req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs1_n,
  output logic              mem_cs2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic              mem_byte_n,
  output logic [15:0]       mem_dq_out,
  output logic [15:0]       mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R1: phase lengths in cycles
  localparam int L_RD    = mx(mx(cyc(T_RC_NS), cyc(T_AA_NS)), cyc(T_OE_NS));
  localparam int L_WR    = mx(mx(cyc(T_WC_NS), cyc(T_WP_NS)), mx(cyc(T_AW_NS), cyc(T_DW_NS)));
  localparam int N_MODE  = cyc(T_MODE_NS);
  localparam int CNT_MAX = mx(mx(L_RD, L_WR), N_MODE);
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_MPRE, S_MPOST, S_RD, S_TURN, S_WR, S_WREC, S_NULL
  } state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   dcnt;
  logic            byte_q;
  logic            op_wr;
  logic            op_mode;
  logic [ADDR_W:0] addr_q;
  logic [15:0]     wdata_q;
  logic [1:0]      be_q;

  logic no_lane;
  logic sel;
  logic wr_act;
  logic rd_act;

  assign no_lane = req_byte_mode ? !req_be[0] : (req_be == 2'b00);
  assign rd_act  = (state == S_RD);
  assign wr_act  = (state == S_WR);
  assign sel     = rd_act || wr_act;

  assign req_ready  = (state == S_IDLE);
  assign mem_cs1_n  = !sel;
  assign mem_cs2    = sel;
  assign mem_we_n   = !wr_act;
  assign mem_oe_n   = !rd_act;
  assign mem_lb_n   = !(sel && (byte_q || be_q[0]));
  assign mem_ub_n   = !(sel && (byte_q || be_q[1]));
  assign mem_byte_n = !byte_q;
  assign mem_addr   = addr_q[ADDR_W:1];
  assign mem_dq_out = byte_q ? {addr_q[0], 7'd0, wdata_q[7:0]} : wdata_q;
  assign mem_dq_oe  = byte_q ? {1'b1, 7'd0, {8{wr_act}}}
                             : {{8{wr_act && be_q[1]}}, {8{wr_act && be_q[0]}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      dcnt      <= '0;
      byte_q    <= 1'b0;
      op_wr     <= 1'b0;
      op_mode   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (sel)
        dcnt <= '0;
      else if (dcnt < CW'(N_MODE))
        dcnt <= dcnt + 1'b1;

      case (state)
        S_IDLE: if (req_valid) begin
          op_wr   <= req_write;
          op_mode <= req_byte_mode;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          be_q    <= req_be;
          cnt     <= '0;
          if (no_lane) begin
            rsp_valid <= !req_write;
            if (!req_write) rsp_rdata <= '0;
            state <= S_NULL;
          end else if (req_byte_mode != byte_q) begin
            state <= S_MPRE;
          end else begin
            state <= req_write ? S_WR : S_RD;
          end
        end
        S_MPRE: if (dcnt >= CW'(N_MODE)) begin
          byte_q <= op_mode;
          cnt    <= '0;
          state  <= S_MPOST;
        end
        S_MPOST: begin
          if (cnt == CW'(N_MODE - 1)) begin
            cnt   <= '0;
            state <= op_wr ? S_WR : S_RD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_RD: begin
          if (cnt == CW'(L_RD - 1)) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= byte_q ? {8'd0, mem_dq_in[7:0]}
                                : {be_q[1] ? mem_dq_in[15:8] : 8'd0,
                                   be_q[0] ? mem_dq_in[7:0]  : 8'd0};
            state <= S_TURN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WR: begin
          if (cnt == CW'(L_WR - 1)) state <= S_WREC;
          else cnt <= cnt + 1'b1;
        end
        S_TURN:  state <= S_IDLE;
        S_WREC:  state <= S_IDLE;
        S_NULL:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs1_n,
  input logic              mem_cs2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_byte_n,
  input logic [15:0]       mem_dq_oe
);

  AST_WE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> $stable(mem_addr)); // R3

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n)); // R3

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe[14:0] == 15'd0)); // R5

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (mem_dq_oe[14:0] == 15'd0)); // R5

  AST_BYTE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_byte_n |-> (mem_dq_oe[14:8] == 7'd0 && mem_dq_oe[15])); // R6

  AST_MODE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mem_byte_n) |-> (mem_cs1_n && !mem_cs2 && $past(mem_cs1_n))); // R7

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2

  AST_BUSY_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R4

  AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs1_n && !mem_cs2)); // R10

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .mem_addr   (mem_addr),
  .mem_cs1_n  (mem_cs1_n),
  .mem_cs2    (mem_cs2),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_byte_n (mem_byte_n),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;
  localparam int AW     = 6;
  localparam int P      = 10;
  localparam int RC_NS  = 61;
  localparam int MD_NS  = 200;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction

  // R1: expected lengths from the timing values
  localparam int L_RD   = cdiv(RC_NS);
  localparam int L_WR   = cdiv(45);
  localparam int N_MODE = cdiv(MD_NS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0, req_byte_mode = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic          req_ready, rsp_valid;
  logic [15:0]   rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_byte_n;
  logic [15:0]   mem_dq_out, mem_dq_oe, mem_dq_in;

  sram_strobe_ctrl #(.CLK_PERIOD_NS(P), .ADDR_W(AW), .T_RC_NS(RC_NS), .T_MODE_NS(MD_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_byte_mode(req_byte_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_byte_n(mem_byte_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model (byte array) and reference image
  logic [7:0] mem  [0:(2<<AW)-1];
  logic [7:0] refm [0:(2<<AW)-1];
  logic       chip_on;
  logic [15:0] dq_drv;
  assign chip_on = !mem_cs1_n && mem_cs2;
  assign dq_drv  = mem_dq_out & mem_dq_oe;

  always_comb begin
    mem_dq_in = '0;
    if (chip_on && !mem_oe_n && mem_we_n) begin
      if (!mem_byte_n)
        mem_dq_in[7:0] = mem[{mem_addr, dq_drv[15]}];
      else begin
        if (!mem_lb_n) mem_dq_in[7:0]  = mem[{mem_addr, 1'b0}];
        if (!mem_ub_n) mem_dq_in[15:8] = mem[{mem_addr, 1'b1}];
      end
    end
  end

  logic          pend = 1'b0, p_byte, p_lb, p_ub;
  logic [AW:0]   p_idx;
  logic [15:0]   p_dat;
  always @(posedge clk) begin
    if (chip_on && !mem_we_n) begin
      pend   <= 1'b1;
      p_byte <= !mem_byte_n;
      p_idx  <= !mem_byte_n ? {mem_addr, dq_drv[15]} : {mem_addr, 1'b0};
      p_dat  <= dq_drv;
      p_lb   <= !mem_lb_n;
      p_ub   <= !mem_ub_n;
    end else if (pend) begin
      pend <= 1'b0;
      if (p_byte) mem[p_idx] <= p_dat[7:0];
      else begin
        if (p_lb) mem[p_idx]        <= p_dat[7:0];
        if (p_ub) mem[p_idx | 'd1]  <= p_dat[15:8];
      end
    end
  end

  // scoreboard
  logic [15:0] expq[$];
  int sel_starts = 0;

  task automatic issue(input bit wr, input bit bm, input int addr, input logic [15:0] d, input logic [1:0] be);
    logic [AW:0] a;
    logic [15:0] e;
    logic nl;
    a  = addr[AW:0];
    nl = bm ? !be[0] : (be == 2'b00);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_byte_mode = bm;
    req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    if (wr) begin
      if (!nl) begin
        if (bm) refm[a] = d[7:0];
        else begin
          if (be[0]) refm[{a[AW:1], 1'b0}] = d[7:0];
          if (be[1]) refm[{a[AW:1], 1'b1}] = d[15:8];
        end
      end
    end else begin
      if (nl) e = 16'h0;
      else if (bm) e = {8'h0, refm[a]};
      else e = {be[1] ? refm[{a[AW:1], 1'b1}] : 8'h0, be[0] ? refm[{a[AW:1], 1'b0}] : 8'h0};
      expq.push_back(e);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (expq.size() == 0) chk(1'b0, "R2 unexpected response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rsp_rdata == e, "R2/R6/R8 read data", rsp_rdata, e);
      end
    end
  end

  // pin-level monitors
  int we_len = 0, oe_len = 0, desel_len = 0, since_mode = 0;
  bit prev_we_lo = 0, prev_oe_lo = 0, prev_on = 0, fresh = 0;
  logic prev_byte_n = 1'b1;
  logic [AW-1:0] prev_addr = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] dmask;
      dmask = mem_byte_n ? 16'hffff : 16'h00ff;
      if (!mem_we_n) we_len++;
      else if (we_len != 0) begin
        chk(we_len == L_WR, "R1/R3 write pulse length", we_len, L_WR);
        we_len = 0;
      end
      if (!mem_oe_n) oe_len++;
      else if (oe_len != 0) begin
        chk(oe_len == L_RD, "R1/R2 read window length", oe_len, L_RD);
        oe_len = 0;
      end
      if (prev_we_lo) chk(mem_addr == prev_addr, "R3 address held through write end", mem_addr, prev_addr);
      if (!mem_oe_n || prev_oe_lo)
        chk((mem_dq_oe & 16'h7fff) == 0, "R5 no drive during/after read", mem_dq_oe, 0);
      if ((mem_dq_oe & dmask) != 0)
        chk(!mem_we_n, "R5 drivers only in write", mem_we_n, 0);
      if (!mem_byte_n)
        chk(mem_dq_oe[14:8] == 0 && mem_dq_oe[15], "R6 byte mode pin use", mem_dq_oe, 16'h8000);
      if (mem_byte_n != prev_byte_n) begin
        chk(desel_len >= N_MODE && !chip_on, "R7 deselect before width change", desel_len, N_MODE);
        fresh = 1; since_mode = 0;
      end
      if (chip_on && fresh) begin
        chk(since_mode >= N_MODE, "R7 deselect after width change", since_mode, N_MODE);
        fresh = 0;
      end
      if (chip_on && !prev_on) sel_starts++;
      if (req_ready) chk(!chip_on, "R10 idle deselected", chip_on, 0);
      desel_len   = chip_on ? 0 : desel_len + 1;
      since_mode++;
      prev_we_lo  = !mem_we_n;
      prev_oe_lo  = !mem_oe_n;
      prev_on     = chip_on;
      prev_addr   = mem_addr;
      prev_byte_n = mem_byte_n;
    end
  end

  task automatic finish_test;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_test();
  end

  task automatic drain;
    int n = 0;
    while ((expq.size() != 0 || !req_ready) && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int s0;
    for (int i = 0; i < (2 << AW); i++) begin
      mem[i]  = 8'((i * 37 + 5) & 255);
      refm[i] = 8'((i * 37 + 5) & 255);
    end
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(mem_cs1_n && !mem_cs2, "R9 chip deselected", {mem_cs1_n, mem_cs2}, 2);
    chk(mem_we_n && mem_oe_n, "R9 strobes high", {mem_we_n, mem_oe_n}, 3);
    chk(mem_dq_oe == 0, "R9 no drivers", mem_dq_oe, 0);
    chk(mem_byte_n == 1'b1, "R9 word mode", mem_byte_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);

    // R2/R3 word accesses, several lane patterns
    issue(1, 0, 10, 16'hA55A, 2'b11);
    issue(0, 0, 10, 16'h0, 2'b11);
    issue(1, 0, 20, 16'h1234, 2'b01);
    issue(1, 0, 30, 16'h5678, 2'b10);
    issue(0, 0, 20, 16'h0, 2'b11);
    issue(0, 0, 30, 16'h0, 2'b10);
    issue(0, 0, 30, 16'h0, 2'b01);
    // R5 read followed at once by write (turnaround), then read back
    issue(0, 0, 40, 16'h0, 2'b11);
    issue(1, 0, 42, 16'hBEEF, 2'b11);
    issue(0, 0, 42, 16'h0, 2'b11);
    // R6 word mode ignores addr bit 0
    issue(0, 0, 43, 16'h0, 2'b11);
    drain();

    // R8 no-lane requests: no strobe, no change, read returns zero
    s0 = sel_starts;
    issue(1, 0, 10, 16'hFFFF, 2'b00);
    issue(0, 0, 10, 16'h0, 2'b00);
    issue(1, 1, 11, 16'h00CC, 2'b10);
    drain();
    chk(sel_starts == s0, "R8 no chip select for empty lanes", sel_starts - s0, 0);
    chk(mem_byte_n == 1'b1, "R8 width unchanged", mem_byte_n, 1);
    issue(0, 0, 10, 16'h0, 2'b11);

    // R6/R7 byte mode accesses
    issue(1, 1, 51, 16'h00C3, 2'b01);
    issue(1, 1, 50, 16'h003C, 2'b11);
    issue(0, 1, 51, 16'h0, 2'b01);
    issue(0, 1, 50, 16'h0, 2'b01);
    issue(0, 1, 11, 16'h0, 2'b01);
    drain();
    chk(mem_byte_n == 1'b0, "R6 byte mode pin low", mem_byte_n, 0);
    // back to word mode; bytes visible as a word
    issue(0, 0, 50, 16'h0, 2'b11);
    issue(1, 0, 60, 16'h9911, 2'b11);
    issue(0, 1, 61, 16'h0, 2'b01);
    issue(0, 0, 60, 16'h0, 2'b11);
    drain();
    chk(expq.size() == 0, "R2 all responses returned", expq.size(), 0);
    finish_test();
  end
endmodule